// File: doc/BRIEF.md
# Crossbar Sneak-Path Reachability Evaluator

This block is a clocked, purely Boolean model of how current spreads through a grid of crossbar tiles. Every tile is a small matrix of conducting/blocking state bits that sit where horizontal and vertical wires cross. Neighbouring tiles can be joined by link bits. A set link bit joins the first or last row wire of a tile to the matching wire of its right neighbour. It can also join the first or last column wire of a tile to the matching wire of the tile below it. Analog levels and resistances are not modelled. Only connectivity is modelled.

Software or a controller loads the cell and link bits while the block is idle. It then pulses `start` with a mask of source row wires and the index of one row wire to observe. From then on, the block widens two activity vectors once per clock. Columns touched by an active row through a set cell become active. Rows touched by an active column become active. Link bits carry activity between joined wires in both directions. Evaluation stops once a step changes nothing, or once the step budget of rows plus columns is used up. The block then pulses `done` and updates `reached`. A Boolean formula (OR of pairwise ANDs, chained clauses, and so on) can be laid into the tiles and evaluated this way.

Top module: `xbar_reach_eval`

## Requirements
- R1: A synchronous active-high reset clears all activity and leaves `busy`, `done` and `reached` at 0.
- R2: A set cell at local row r, column c of a tile conducts both ways: row r to column c, and column c back to row r. A path from a source row through a cell to a column, and on through a second set cell to another row, reaches that row.
- R3: Activity starts only on the row wires set in `src_rows`. A row reaches nothing through cleared cells. With an all-zero mask, no row is reached.
- R4: Horizontal link index `2*(ti*(NET_COLS-1)+tj)+e` joins row wire 0 (e=0) or row wire TILE_ROWS-1 (e=1) of tile (ti,tj) with the same row of tile (ti,tj+1). A set link conducts and a cleared link does not.
- R5: Vertical link index `NH + 2*(ti*NET_COLS+tj)+e` joins column 0 (e=0) or column TILE_COLS-1 (e=1) of tile (ti,tj) with the same column of tile (ti+1,tj), where NH is the number of horizontal links.
- R6: In a tile whose rows 0 and 1 hold two literal vectors a and b (other rows clear), row 1 is reached from row 0 exactly when (a & b) is nonzero.
- R7: Once a step leaves both vectors unchanged, or after TILE-derived rows+columns steps, `done` goes high for exactly one cycle and `busy` falls with it. An evaluation that needs k widening steps raises `done` k+1 clocks after the clock that sampled `start`.
- R8: A `start` pulse while `busy` is high is ignored. It changes neither the sources, nor the observed row, nor the timing.
- R9: Cell writes and link writes presented while `busy` is high are ignored.
- R10: `reached` holds its value between `done` pulses.

Global row wire numbering: tile t = ti*NET_COLS+tj owns row wires t*TILE_ROWS .. t*TILE_ROWS+TILE_ROWS-1. Columns are numbered the same way with TILE_COLS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cell_we | input | 1 | Write one tile row of cell bits (idle only) |
| cell_tile | input | TW | Tile index for the cell write |
| cell_row | input | RW | Local row within the tile |
| cell_bits | input | TILE_COLS | New cell bits, bit c = column c |
| link_we | input | 1 | Write one link bit (idle only) |
| link_idx | input | LW | Link index (R4/R5 numbering) |
| link_val | input | 1 | New link value |
| start | input | 1 | Begin an evaluation when idle |
| src_rows | input | NRW | Source row wire mask |
| out_row | input | NW | Row wire to report |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle end-of-evaluation pulse |
| reached | output | 1 | Whether `out_row` became active |

## Verification
The checker assumes that `start` is meaningful only while idle. It also assumes that the configuration written before a start stays fixed for that evaluation. The block enforces both assumptions itself, and the bench breaks them on purpose only in the R8 and R9 scenarios. All indices that the bench drives lie within the tile, row, link and wire ranges of the default parameters. That way, no check depends on how out-of-range writes are discarded. Every scenario starts from a fully cleared configuration, so the results of earlier tests cannot leak into later ones.

// File: rtl/xbar_reach_pkg.sv
package xbar_reach_pkg;
  function automatic int idx_bits(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/xb_cell_array.sv
module xb_cell_array #(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int TILES = 4,
  parameter int TW    = 2,
  parameter int RW    = 2
) (
  input  logic                  clk,
  input  logic                  wr_en,
  input  logic [TW-1:0]         wr_tile,
  input  logic [RW-1:0]         wr_row,
  input  logic [COLS-1:0]       wr_bits,
  input  logic [TILES*ROWS-1:0] row_act,
  input  logic [TILES*COLS-1:0] col_act,
  output logic [TILES*ROWS-1:0] row_hit,
  output logic [TILES*COLS-1:0] col_hit
);
  logic [COLS-1:0] mem [TILES][ROWS];

  always_ff @(posedge clk) begin
    if (wr_en && (int'(wr_tile) < TILES) && (int'(wr_row) < ROWS))
      mem[wr_tile][wr_row] <= wr_bits;
  end

  for (genvar t = 0; t < TILES; t++) begin : g_tile
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      assign row_hit[t*ROWS+r] = |(mem[t][r] & col_act[t*COLS +: COLS]);
    end
    for (genvar c = 0; c < COLS; c++) begin : g_col
      logic acc;
      always_comb begin
        acc = 1'b0;
        for (int r = 0; r < ROWS; r++)
          acc = acc | (mem[t][r][c] & row_act[t*ROWS+r]);
      end
      assign col_hit[t*COLS+c] = acc;
    end
  end
endmodule

// File: rtl/xb_link_net.sv
module xb_link_net #(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int NR    = 2,
  parameter int NC    = 2,
  parameter int NH    = 4,
  parameter int NL    = 8,
  parameter int LW    = 3,
  parameter int NRW   = 16,
  parameter int NCW   = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [LW-1:0]  wr_idx,
  input  logic           wr_val,
  input  logic [NRW-1:0] row_act,
  input  logic [NCW-1:0] col_act,
  output logic [NRW-1:0] row_hit,
  output logic [NCW-1:0] col_hit
);
  logic [NL-1:0] link_q;

  always_ff @(posedge clk) begin
    if (rst) link_q <= '0;
    else if (wr_en && (int'(wr_idx) < NL)) link_q[wr_idx] <= wr_val;
  end

  always_comb begin
    row_hit = '0;
    for (int ti = 0; ti < NR; ti++)
      for (int tj = 0; tj < NC-1; tj++)
        for (int e = 0; e < 2; e++) begin
          int a, b;
          a = (ti*NC + tj) * ROWS + ((e == 1) ? ROWS-1 : 0);
          b = a + ROWS;
          if (link_q[2*(ti*(NC-1)+tj)+e]) begin
            row_hit[a] = row_hit[a] | row_act[b];
            row_hit[b] = row_hit[b] | row_act[a];
          end
        end
  end

  always_comb begin
    col_hit = '0;
    for (int ti = 0; ti < NR-1; ti++)
      for (int tj = 0; tj < NC; tj++)
        for (int e = 0; e < 2; e++) begin
          int a, b;
          a = (ti*NC + tj) * COLS + ((e == 1) ? COLS-1 : 0);
          b = a + NC*COLS;
          if (link_q[NH + 2*(ti*NC+tj)+e]) begin
            col_hit[a] = col_hit[a] | col_act[b];
            col_hit[b] = col_hit[b] | col_act[a];
          end
        end
  end
endmodule

// File: rtl/xb_step_ctrl.sv
module xb_step_ctrl #(
  parameter int NRW   = 16,
  parameter int NCW   = 16,
  parameter int NW    = 4,
  parameter int LIMIT = 32,
  parameter int CW    = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [NRW-1:0] src_rows,
  input  logic [NW-1:0]  out_row,
  input  logic [NRW-1:0] row_hit,
  input  logic [NCW-1:0] col_hit,
  output logic [NRW-1:0] row_act,
  output logic [NCW-1:0] col_act,
  output logic           busy,
  output logic           done,
  output logic           reached
);
  logic [NRW-1:0] row_nx;
  logic [NCW-1:0] col_nx;
  logic [CW-1:0]  steps;
  logic [NW-1:0]  sel_q;
  logic           settled, spent;

  assign row_nx  = row_act | row_hit;
  assign col_nx  = col_act | col_hit;
  assign settled = (row_nx == row_act) && (col_nx == col_act);
  assign spent   = (steps == CW'(LIMIT-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      row_act <= '0;
      col_act <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      reached <= 1'b0;
      steps   <= '0;
      sel_q   <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          row_act <= src_rows;
          col_act <= '0;
          busy    <= 1'b1;
          steps   <= '0;
          sel_q   <= out_row;
        end
      end else begin
        row_act <= row_nx;
        col_act <= col_nx;
        steps   <= steps + 1'b1;
        if (settled || spent) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          reached <= row_nx[sel_q];
        end
      end
    end
  end
endmodule

// File: rtl/xbar_reach_eval.sv
module xbar_reach_eval
  import xbar_reach_pkg::*;
#(
  parameter int TILE_ROWS = 4,
  parameter int TILE_COLS = 4,
  parameter int NET_ROWS  = 2,
  parameter int NET_COLS  = 2,
  localparam int NT    = NET_ROWS * NET_COLS,
  localparam int NRW   = NT * TILE_ROWS,
  localparam int NCW   = NT * TILE_COLS,
  localparam int NH    = NET_ROWS * (NET_COLS-1) * 2,
  localparam int NV    = (NET_ROWS-1) * NET_COLS * 2,
  localparam int NL    = NH + NV,
  localparam int TW    = idx_bits(NT),
  localparam int RW    = idx_bits(TILE_ROWS),
  localparam int LW    = idx_bits(NL),
  localparam int NW    = idx_bits(NRW),
  localparam int LIMIT = NRW + NCW,
  localparam int CW    = idx_bits(LIMIT + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cell_we,
  input  logic [TW-1:0]        cell_tile,
  input  logic [RW-1:0]        cell_row,
  input  logic [TILE_COLS-1:0] cell_bits,
  input  logic                 link_we,
  input  logic [LW-1:0]        link_idx,
  input  logic                 link_val,
  input  logic                 start,
  input  logic [NRW-1:0]       src_rows,
  input  logic [NW-1:0]        out_row,
  output logic                 busy,
  output logic                 done,
  output logic                 reached
);
  logic [NRW-1:0] row_act, cell_row_hit, link_row_hit;
  logic [NCW-1:0] col_act, cell_col_hit, link_col_hit;

  xb_cell_array #(
    .ROWS(TILE_ROWS), .COLS(TILE_COLS), .TILES(NT), .TW(TW), .RW(RW)
  ) u_cells (
    .clk(clk), .wr_en(cell_we && !busy), .wr_tile(cell_tile),
    .wr_row(cell_row), .wr_bits(cell_bits),
    .row_act(row_act), .col_act(col_act),
    .row_hit(cell_row_hit), .col_hit(cell_col_hit)
  );

  xb_link_net #(
    .ROWS(TILE_ROWS), .COLS(TILE_COLS), .NR(NET_ROWS), .NC(NET_COLS),
    .NH(NH), .NL(NL), .LW(LW), .NRW(NRW), .NCW(NCW)
  ) u_links (
    .clk(clk), .rst(rst), .wr_en(link_we && !busy), .wr_idx(link_idx),
    .wr_val(link_val), .row_act(row_act), .col_act(col_act),
    .row_hit(link_row_hit), .col_hit(link_col_hit)
  );

  xb_step_ctrl #(
    .NRW(NRW), .NCW(NCW), .NW(NW), .LIMIT(LIMIT), .CW(CW)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .src_rows(src_rows),
    .out_row(out_row), .row_hit(cell_row_hit | link_row_hit),
    .col_hit(cell_col_hit | link_col_hit),
    .row_act(row_act), .col_act(col_act),
    .busy(busy), .done(done), .reached(reached)
  );
endmodule

// File: rtl/xbar_reach_eval_chk.sv
module xbar_reach_eval_chk #(
  parameter int NRW   = 16,
  parameter int NCW   = 16,
  parameter int LIMIT = 32
) (
  input logic           clk,
  input logic           rst,
  input logic           busy,
  input logic           done,
  input logic           reached,
  input logic [NRW-1:0] row_act,
  input logic [NCW-1:0] col_act
);
  int unsigned busy_run;

  always_ff @(posedge clk) begin
    if (rst || !busy) busy_run <= 0;
    else busy_run <= busy_run + 1;
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!busy && !done && !reached));

  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r7_busy_ends_with_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  a_r7_step_budget: assert property (@(posedge clk) disable iff (rst)
    busy |-> (busy_run <= LIMIT));

  a_r2_rows_only_grow: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> ((row_act & $past(row_act)) == $past(row_act)));

  a_r2_cols_only_grow: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> ((col_act & $past(col_act)) == $past(col_act)));

  a_r10_reached_hold: assert property (@(posedge clk) disable iff (rst)
    !done |=> (done || $stable(reached)));
endmodule

bind xbar_reach_eval xbar_reach_eval_chk #(
  .NRW(NRW), .NCW(NCW), .LIMIT(LIMIT)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .reached(reached),
  .row_act(row_act), .col_act(col_act)
);

// File: tb/xbar_reach_eval_bench.sv
module xbar_reach_eval_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cell_we = 1'b0;
  logic [1:0]  cell_tile = '0;
  logic [1:0]  cell_row = '0;
  logic [3:0]  cell_bits = '0;
  logic        link_we = 1'b0;
  logic [2:0]  link_idx = '0;
  logic        link_val = 1'b0;
  logic        start = 1'b0;
  logic [15:0] src_rows = '0;
  logic [3:0]  out_row = '0;
  logic        busy, done, reached;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  xbar_reach_eval u_xbar_reach_eval (
    .clk(clk), .rst(rst), .cell_we(cell_we), .cell_tile(cell_tile),
    .cell_row(cell_row), .cell_bits(cell_bits), .link_we(link_we),
    .link_idx(link_idx), .link_val(link_val), .start(start),
    .src_rows(src_rows), .out_row(out_row), .busy(busy), .done(done),
    .reached(reached)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_row(input int t, input int r, input int bits);
    @(negedge clk);
    cell_we = 1'b1; cell_tile = 2'(t); cell_row = 2'(r); cell_bits = 4'(bits);
    @(negedge clk);
    cell_we = 1'b0;
  endtask

  task automatic write_link(input int idx, input bit v);
    @(negedge clk);
    link_we = 1'b1; link_idx = 3'(idx); link_val = v;
    @(negedge clk);
    link_we = 1'b0;
  endtask

  task automatic clear_all();
    for (int t = 0; t < 4; t++)
      for (int r = 0; r < 4; r++) write_row(t, r, 0);
    for (int l = 0; l < 8; l++) write_link(l, 1'b0);
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    for (int k = 0; k < 100; k++) begin
      @(posedge clk); @(negedge clk);
      cyc++;
      if (done) break;
    end
  endtask

  task automatic run(input int src, input int outw, output bit res, output int cyc);
    @(negedge clk);
    start = 1'b1; src_rows = 16'(src); out_row = 4'(outw);
    @(negedge clk);
    start = 1'b0;
    wait_done(cyc);
    res = reached;
  endtask

  task automatic t_reset();
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    check(done == 1'b0, "R1 done", int'(done), 0);
    check(reached == 1'b0, "R1 reached", int'(reached), 0);
  endtask

  task automatic t_chain();
    bit res; int cyc;
    clear_all();
    write_row(0, 0, 4'b0001);
    write_row(0, 3, 4'b0001);
    run(16'h0001, 3, res, cyc);
    check(res == 1'b1, "R2 row0-col0-row3", int'(res), 1);
    check(cyc == 3, "R7 done after two steps", cyc, 3);
    @(negedge clk);
    check(done == 1'b0, "R7 done single cycle", int'(done), 0);
    repeat (5) @(negedge clk);
    check(reached == 1'b1, "R10 reached held", int'(reached), 1);
    run(16'h0001, 2, res, cyc);
    check(res == 1'b0, "R3 row without cell", int'(res), 0);
    run(16'h0000, 3, res, cyc);
    check(res == 1'b0, "R3 empty source mask", int'(res), 0);
    check(cyc == 1, "R7 settles at once", cyc, 1);
  endtask

  task automatic t_hlink();
    bit res; int cyc;
    clear_all();
    write_row(0, 0, 4'b0001);
    write_row(0, 3, 4'b0001);
    run(16'h0001, 7, res, cyc);
    check(res == 1'b0, "R4 last-row link off", int'(res), 0);
    write_link(1, 1'b1);
    run(16'h0001, 7, res, cyc);
    check(res == 1'b1, "R4 last-row link on", int'(res), 1);
    run(16'h0001, 4, res, cyc);
    check(res == 1'b0, "R4 first-row link off", int'(res), 0);
    write_link(0, 1'b1);
    run(16'h0001, 4, res, cyc);
    check(res == 1'b1, "R4 first-row link on", int'(res), 1);
  endtask

  task automatic t_vlink();
    bit res; int cyc;
    clear_all();
    write_row(0, 0, 4'b1001);
    write_row(2, 2, 4'b0001);
    write_row(2, 1, 4'b1000);
    run(16'h0001, 10, res, cyc);
    check(res == 1'b0, "R5 first-col link off", int'(res), 0);
    write_link(4, 1'b1);
    run(16'h0001, 10, res, cyc);
    check(res == 1'b1, "R5 first-col link on", int'(res), 1);
    run(16'h0001, 9, res, cyc);
    check(res == 1'b0, "R5 last-col link off", int'(res), 0);
    write_link(5, 1'b1);
    run(16'h0001, 9, res, cyc);
    check(res == 1'b1, "R5 last-col link on", int'(res), 1);
  endtask

  task automatic t_pairs();
    bit res; int cyc;
    int av[4] = '{4'b1010, 4'b0110, 4'b0000, 4'b1111};
    int bv[4] = '{4'b0101, 4'b0100, 4'b1111, 4'b1000};
    clear_all();
    for (int k = 0; k < 4; k++) begin
      write_row(3, 0, av[k]);
      write_row(3, 1, bv[k]);
      run(16'h1000, 13, res, cyc);
      check(res == ((av[k] & bv[k]) != 0), "R6 pair product",
            int'(res), int'((av[k] & bv[k]) != 0));
    end
  endtask

  task automatic t_busy_start();
    int cyc;
    clear_all();
    write_row(0, 0, 4'b0001);
    write_row(0, 3, 4'b0001);
    @(negedge clk);
    start = 1'b1; src_rows = 16'h0001; out_row = 4'd3;
    @(negedge clk);
    src_rows = 16'h0000; out_row = 4'd2;
    wait_done(cyc);
    start = 1'b0;
    check(reached == 1'b1, "R8 restart ignored result", int'(reached), 1);
    check(cyc == 3, "R8 restart ignored timing", cyc, 3);
  endtask

  task automatic t_busy_write();
    bit res; int cyc;
    clear_all();
    write_row(0, 0, 4'b0001);
    write_row(0, 3, 4'b0001);
    @(negedge clk);
    start = 1'b1; src_rows = 16'h0001; out_row = 4'd3;
    @(negedge clk);
    start = 1'b0;
    cell_we = 1'b1; cell_tile = 2'd0; cell_row = 2'd3; cell_bits = 4'b0000;
    link_we = 1'b1; link_idx = 3'd0; link_val = 1'b1;
    wait_done(cyc);
    cell_we = 1'b0; link_we = 1'b0;
    check(reached == 1'b1, "R9 busy write result", int'(reached), 1);
    run(16'h0001, 3, res, cyc);
    check(res == 1'b1, "R9 cell write dropped", int'(res), 1);
    run(16'h0001, 4, res, cyc);
    check(res == 1'b0, "R9 link write dropped", int'(res), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_chain();
    t_hlink();
    t_vlink();
    t_pairs();
    t_busy_start();
    t_busy_write();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule